// File: doc/BRIEF.md
# Invalidation Completion Interrupt Controller

This block decides when a finished wait request turns into an interrupt. The queue engine sends it a one-cycle completion pulse. The block then keeps track of three things: whether software has already been told about the completion, whether the interrupt is being held back by a mask, and whether a held-back interrupt is still owed. A completion that arrives while an earlier one is still unacknowledged is dropped. A completion that arrives while the mask is set is remembered as pending. It is delivered when software clears the mask, or it is discarded if software acknowledges the completion first.

Software reaches the block through one write port and one read port, both with a 3-bit register select. There are five registers: completion status, event control, message data, message address and upper message address. The message data and address registers are plain storage; building the interrupt message from them is done elsewhere. The request output `irq_o` is a single-cycle pulse.

The core is a three-state machine:
- CS_CLEAR: nothing is outstanding.
- CS_PENDING: a completion has been recorded and its interrupt is held by the mask.
- CS_NOTIFIED: a completion has been recorded and its interrupt has been issued.

The transitions are:
- T_LIVE: CS_CLEAR to CS_NOTIFIED on an unmasked completion. Fires the interrupt.
- T_HOLD: CS_CLEAR to CS_PENDING on a masked completion.
- T_RELEASE: CS_PENDING to CS_NOTIFIED when a control write leaves the mask clear. Fires the interrupt.
- T_ACK: any state to CS_CLEAR on a status write with bit 0 set.

Every other input leaves the state where it is.

Top module: `cic_top`

## Requirements
- R1: After synchronous reset the register reads are: status (select 0) reads 0, control (select 1) reads 0x8000_0000 (mask bit 31 set, pending bit 30 clear), data (select 2) reads 0, address (select 3) reads 0 and upper address (select 4) reads 0. `irq_o` is low.
- R2: A completion pulse while status bit 0 is clear and the mask is clear sets status bit 0. It produces an `irq_o` pulse, and control bit 30 reads 0 afterwards.
- R3: A completion pulse while status bit 0 is clear and the mask is set sets status bit 0 and control bit 30. No `irq_o` pulse is produced.
- R4: A completion pulse while status bit 0 is set changes no register and produces no `irq_o` pulse.
- R5: Status bit 0 is write-1-to-clear. A status write with data bit 0 equal to 0 leaves it unchanged. A write that clears it also clears control bit 30 and produces no `irq_o` pulse.
- R6: In the control register only bit 31 (the mask) is writable; all other bits read 0 except pending bit 30. A control write that leaves bit 31 clear while bit 30 is set produces an `irq_o` pulse and clears bit 30.
- R7: The data register (select 2) stores and reads back all 32 bits.
- R8: The address register (select 3) stores bits 31:2; bits 1:0 always read 0.
- R9: The upper address register (select 4) always reads 0, and writes to it are ignored.
- R10: When a completion pulse and a register write arrive in the same cycle, the write takes effect first and the completion is then judged against the updated state.
- R11: `irq_o` is high for exactly one cycle, registered on the clock edge that samples the triggering event. It is never high unless that edge sampled a completion pulse or a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_i | input | 1 | One-cycle completion pulse from the queue engine |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write register select (0 status, 1 control, 2 data, 3 address, 4 upper address) |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Read register select, same codes as write |
| rd_data_o | output | 32 | Read data (combinational from rd_sel_i) |
| irq_o | output | 1 | Single-cycle completion interrupt request |

## Verification
A wrong state in the machine becomes visible at the ports in one of two ways. The first is on the status or control read in the very next cycle: bit 0 or bit 30 disagrees with the history of completions, acknowledgements and mask writes. The second is through `irq_o`, which fires one edge after the fault or stays silent when it should fire. A lost pending bit shows up when the mask is cleared, because no pulse follows. A status bit stuck high shows up as a completion that is silently dropped. The bench therefore reads every register after every cycle and compares `irq_o` each cycle, so no divergence survives more than one clock.

// File: rtl/cic_pkg.sv
package cic_pkg;
    typedef enum logic [1:0] {
        CS_CLEAR    = 2'd0,
        CS_PENDING  = 2'd1,
        CS_NOTIFIED = 2'd2
    } cstate_e;

    localparam int SEL_STS   = 0;
    localparam int SEL_CTL   = 1;
    localparam int SEL_DATA  = 2;
    localparam int SEL_ADDR  = 3;
    localparam int SEL_UADDR = 4;
endpackage

// File: rtl/cic_fsm.sv
module cic_fsm
    import cic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmpl,
    input  logic ack_wr,
    input  logic ctl_wr,
    input  logic ctl_mask_bit,
    output logic wc,
    output logic pend,
    output logic mask,
    output logic irq
);
    cstate_e state_q, state_d;
    logic    mask_q, mask_d;
    logic    fire_d;
    logic    irq_q;

    // Writes are applied first, then the completion sees the result.
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        fire_d  = 1'b0;
        if (ack_wr) begin
            state_d = CS_CLEAR;                 // T_ACK
        end
        if (ctl_wr) begin
            mask_d = ctl_mask_bit;
            if (!mask_d && state_d == CS_PENDING) begin
                state_d = CS_NOTIFIED;          // T_RELEASE
                fire_d  = 1'b1;
            end
        end
        if (cmpl) begin
            unique case (state_d)
                CS_CLEAR: begin
                    if (mask_d) begin
                        state_d = CS_PENDING;   // T_HOLD
                    end else begin
                        state_d = CS_NOTIFIED;  // T_LIVE
                        fire_d  = 1'b1;
                    end
                end
                CS_PENDING, CS_NOTIFIED: begin
                    state_d = state_d;          // earlier completion unserviced
                end
                default: state_d = CS_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            irq_q  <= fire_d;
        end
    end

    assign wc   = (state_q != CS_CLEAR);
    assign pend = (state_q == CS_PENDING);
    assign mask = mask_q;
    assign irq  = irq_q;
endmodule

// File: rtl/cic_regs.sv
module cic_regs
    import cic_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SW       = 3,
    parameter int ADDR_LSB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] rd_sel,
    input  logic          wc,
    input  logic          pend,
    input  logic          mask,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0]        data_q;
    logic [DW-1:ADDR_LSB] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            addr_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SW'(SEL_DATA)) data_q <= wr_data;
            if (wr_sel == SW'(SEL_ADDR)) addr_q <= wr_data[DW-1:ADDR_LSB];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SW'(SEL_STS):  rd_data[0] = wc;
            SW'(SEL_CTL):  begin
                rd_data[DW-1] = mask;
                rd_data[DW-2] = pend;
            end
            SW'(SEL_DATA): rd_data = data_q;
            SW'(SEL_ADDR): rd_data[DW-1:ADDR_LSB] = addr_q;
            default:       rd_data = '0;   // upper address and unused codes
        endcase
    end
endmodule

// File: rtl/cic_top.sv
module cic_top
    import cic_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SW       = 3,
    parameter int ADDR_LSB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmpl_i,
    input  logic          wr_en_i,
    input  logic [SW-1:0] wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [SW-1:0] rd_sel_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);
    localparam int MASK_BIT = DW - 1;

    logic ack_wr, ctl_wr;
    logic wc_bit, pend_bit, mask_bit;

    assign ack_wr = wr_en_i && (wr_sel_i == SW'(SEL_STS)) && wr_data_i[0];
    assign ctl_wr = wr_en_i && (wr_sel_i == SW'(SEL_CTL));

    cic_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cmpl         (cmpl_i),
        .ack_wr       (ack_wr),
        .ctl_wr       (ctl_wr),
        .ctl_mask_bit (wr_data_i[MASK_BIT]),
        .wc           (wc_bit),
        .pend         (pend_bit),
        .mask         (mask_bit),
        .irq          (irq_o)
    );

    cic_regs #(.DW(DW), .SW(SW), .ADDR_LSB(ADDR_LSB)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .rd_sel  (rd_sel_i),
        .wc      (wc_bit),
        .pend    (pend_bit),
        .mask    (mask_bit),
        .rd_data (rd_data_o)
    );
endmodule

// File: rtl/cic_checker.sv
module cic_checker
    import cic_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SW       = 3,
    parameter int ADDR_LSB = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cmpl,
    input logic          wr_en,
    input logic [SW-1:0] wr_sel,
    input logic [DW-1:0] wr_data,
    input logic [SW-1:0] rd_sel,
    input logic [DW-1:0] rd_data,
    input logic          irq,
    input logic          wc,
    input logic          pend,
    input logic          mask
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask && !wc && !pend && !irq));

    p_cmpl_live_r2: assert property (@(posedge clk) disable iff (rst)
        (cmpl && !wc && !mask && !wr_en) |=> (irq && wc && !pend));

    p_cmpl_held_r3: assert property (@(posedge clk) disable iff (rst)
        (cmpl && !wc && mask && !wr_en) |=> (!irq && wc && pend));

    p_cmpl_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (cmpl && wc && !wr_en) |=> (wc && $stable(pend) && !irq));

    p_pend_has_status_r5: assert property (@(posedge clk) disable iff (rst)
        pend |-> wc);

    p_unmask_release_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SW'(SEL_CTL) && !wr_data[DW-1] && pend) |=> (irq && !pend));

    p_addr_low_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == SW'(SEL_ADDR)) |-> (rd_data[ADDR_LSB-1:0] == '0));

    p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == SW'(SEL_UADDR)) |-> (rd_data == '0));

    p_irq_has_cause_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(cmpl || (wr_en && wr_sel == SW'(SEL_CTL))));
endmodule

bind cic_top cic_checker #(.DW(DW), .SW(SW), .ADDR_LSB(ADDR_LSB)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cmpl    (cmpl_i),
    .wr_en   (wr_en_i),
    .wr_sel  (wr_sel_i),
    .wr_data (wr_data_i),
    .rd_sel  (rd_sel_i),
    .rd_data (rd_data_o),
    .irq     (irq_o),
    .wc      (wc_bit),
    .pend    (pend_bit),
    .mask    (mask_bit)
);

// File: tb/cic_top_test.sv
`timescale 1ns/100ps
module cic_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmpl_i;
    logic        wr_en_i;
    logic [2:0]  wr_sel_i;
    logic [31:0] wr_data_i;
    logic [2:0]  rd_sel_i;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state built from the requirements
    bit          m_wc, m_pend, m_mask;
    logic [31:0] m_data, m_addr;

    always #5 clk = ~clk;

    cic_top uut (
        .clk       (clk),
        .rst       (rst),
        .cmpl_i    (cmpl_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int sel);
        case (sel)
            0: return {31'b0, m_wc};
            1: return {m_mask, m_pend, 30'b0};
            2: return m_data;
            3: return {m_addr[31:2], 2'b00};
            default: return 32'b0;
        endcase
    endfunction

    // Returns expected irq; updates model (R5, R6, R7, R8, R9, R10, R2, R3, R4)
    function automatic bit model_step(input bit c, input bit we, input int sel, input logic [31:0] d);
        bit fire = 1'b0;
        if (we && sel == 0 && d[0]) begin m_wc = 1'b0; m_pend = 1'b0; end
        if (we && sel == 1) begin
            m_mask = d[31];
            if (m_pend && !m_mask) begin fire = 1'b1; m_pend = 1'b0; end
        end
        if (we && sel == 2) m_data = d;
        if (we && sel == 3) m_addr = d;
        if (c && !m_wc) begin
            m_wc = 1'b1;
            if (m_mask) m_pend = 1'b1;
            else        fire   = 1'b1;
        end
        return fire;
    endfunction

    task automatic read_all();
        for (int s = 0; s < 5; s++) begin
            rd_sel_i = 3'(s);
            #0.5;
            case (s)
                0: check("R5 status",  rd_data_o, exp_read(s));
                1: check("R6 control", rd_data_o, exp_read(s));
                2: check("R7 data",    rd_data_o, exp_read(s));
                3: check("R8 address", rd_data_o, exp_read(s));
                default: check("R9 upper", rd_data_o, exp_read(s));
            endcase
        end
    endtask

    task automatic step(input bit c, input bit we, input int sel, input logic [31:0] d, input string tag);
        bit exp_irq;
        cmpl_i    = c;
        wr_en_i   = we;
        wr_sel_i  = 3'(sel);
        wr_data_i = d;
        exp_irq   = model_step(c, we, sel, d);
        @(posedge clk);
        #1;
        cmpl_i  = 1'b0;
        wr_en_i = 1'b0;
        check({tag, " irq"}, {31'b0, irq_o}, {31'b0, exp_irq});
        read_all();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        rst = 1'b1; cmpl_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0; rd_sel_i = 0;
        m_wc = 0; m_pend = 0; m_mask = 1; m_data = 0; m_addr = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'b0);
        for (int s = 0; s < 5; s++) begin
            rd_sel_i = 3'(s);
            #0.5;
            check("R1 read", rd_data_o, exp_read(s));
        end

        step(0, 1, 1, 32'h0000_0000, "R6");   // unmask
        step(1, 0, 0, 0,             "R2");   // live completion fires
        step(0, 0, 0, 0,             "R11");  // single pulse
        step(1, 0, 0, 0,             "R4");   // dropped
        step(0, 1, 0, 32'hFFFF_FFFE, "R5");   // bit0=0 keeps status
        step(0, 1, 0, 32'h0000_0001, "R5");   // W1C
        step(0, 1, 1, 32'h7FFF_FFFF, "R6");   // mask set? no: bit31=0, other bits ignored
        step(0, 1, 1, 32'h8000_0000, "R6");   // mask
        step(1, 0, 0, 0,             "R3");   // held
        step(0, 1, 1, 32'h0000_0000, "R6");   // release fires
        step(0, 1, 1, 32'hC000_0000, "R6");   // mask again
        step(0, 1, 0, 32'h0000_0001, "R5");
        step(1, 0, 0, 0,             "R3");
        step(0, 1, 0, 32'h0000_0001, "R5");   // ack discards pending, no irq
        step(1, 0, 0, 0,             "R3");
        step(1, 1, 0, 32'h0000_0001, "R10");  // ack then completion: held again
        step(1, 1, 1, 32'h0000_0000, "R10");  // unmask fires, completion dropped
        step(1, 1, 0, 32'h0000_0001, "R10");  // ack then live completion fires
        step(0, 1, 2, 32'hDEAD_BEEF, "R7");
        step(0, 1, 3, 32'hFFFF_FFFF, "R8");
        step(0, 1, 4, 32'hFFFF_FFFF, "R9");

        for (int i = 0; i < 400; i++) begin
            bit          c  = ($urandom_range(0, 2) == 0);
            bit          we = ($urandom_range(0, 1) == 1);
            int          sl = $urandom_range(0, 5);
            logic [31:0] d  = $urandom;
            step(c, we, sl, d, "R11 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule